// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Filter

This block sits between a UART receive deserializer and the receive FIFO. It takes 9-bit received words from a valid/ready stream and writes 8-bit bytes to the FIFO through a second valid/ready stream. With the multidrop enable set, the ninth bit of each word tells the two kinds of word apart: a 1 marks an address word and a 0 marks a data word. In this mode the parity check upstream is turned off, because the ninth bit takes the place of the parity bit. Every address word sets a sticky interrupt flag. The flag stays set until the host pulses a clear strobe.

There are two ways to use the block. With multidrop alone, every word reaches the FIFO, and the host tells addresses from data by watching the interrupt flag. With multidrop and the filter enable both set, the block compares each address word with the station address. It then forwards only the data words that follow a matching address. Address words never reach the FIFO in this mode. The station address is either the full 8-bit register, or the register's high nibble joined to four input pins. The pins pass through a two-flop synchronizer before they are used.

Back-pressure rules: `in_ready` is high whenever the output holding register is empty or is being drained in the same cycle. An accepted word that is forwarded appears on `out_valid`/`out_data` one clock after acceptance. The output then holds stable until `out_ready` is high. A word that is discarded is still consumed, so the upstream stream never stalls on it.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `addr_irq` is 0, `in_ready` is 1, and the filter starts in the not-selected state.
- R2: With `cfg_multidrop` at 0, every accepted word is forwarded one clock later with `out_data` equal to bits [7:0]. Bit 8 is ignored, `addr_irq` stays 0, and `parity_check_en` is 1.
- R3: With `cfg_multidrop` at 1 and `cfg_filter` at 0, both address words (bit 8 = 1) and data words (bit 8 = 0) are forwarded as bits [7:0], and `parity_check_en` is 0.
- R4: Each accepted word with bit 8 = 1 sets `addr_irq` while multidrop is on. The flag holds until the cycle after an `addr_irq_clr` pulse. If an address word is accepted in the same cycle as the clear, the flag stays set.
- R5: With multidrop and filter both set, data words accepted after an address word equal to the station address are forwarded.
- R6: With filtering active, data words after a non-matching address are consumed and discarded, and address words are never forwarded.
- R7: The filter is not selected after reset and whenever filtering is inactive. After filtering is switched on, data is discarded until a matching address arrives.
- R8: With `cfg_pin_addr` at 0, the station address is `station_addr[7:0]`. With it at 1, the address is {`station_addr[7:4]`, `addr_pins[3:0]`}, and a pin change takes effect within 3 clocks.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds stable, `in_ready` is 0, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multidrop | input | 1 | Nine-bit multidrop mode enable |
| cfg_filter | input | 1 | Automatic address filter enable (used with multidrop) |
| cfg_pin_addr | input | 1 | Take the low address nibble from the pins |
| station_addr | input | 8 | Station address register |
| addr_pins | input | 4 | Asynchronous address input pins |
| in_valid | input | 1 | Received word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 9 | Received word; bit 8 is the ninth bit |
| out_valid | output | 1 | FIFO write request |
| out_ready | input | 1 | FIFO can take a byte |
| out_data | output | 8 | Byte for the FIFO |
| addr_irq | output | 1 | Sticky address-received flag |
| addr_irq_clr | input | 1 | Clear strobe for the flag |
| parity_check_en | output | 1 | Parity check allowed upstream (0 in multidrop) |

## Verification
The main risk is the hidden selected state. If it is wrong, data bytes show up at the FIFO or go missing, starting with the first data word after the address that set that state. The bench therefore checks the output after every single word, against a model that tracks selection across random sequences of addresses, data words and configuration changes. A stale synchronized pin value is exposed by the first address word sent three clocks after a pin change. A wrong flag is visible on `addr_irq` one clock after the word or clear that should have changed it.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  // Classification of an accepted word
  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,   // multidrop off: ninth bit not interpreted
    WK_DATA  = 2'd1,   // multidrop data word
    WK_ADDR  = 2'd2    // multidrop address word
  } word_kind_t;

  function automatic word_kind_t classify(input logic multidrop, input logic ninth);
    if (!multidrop) return WK_PLAIN;
    return ninth ? WK_ADDR : WK_DATA;
  endfunction
endpackage

// File: rtl/mdrop_addr_src.sv
module mdrop_addr_src #(
  parameter int ADDR_W = 8,
  parameter int PIN_W  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PIN_W-1:0]  pins,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int HI_W = ADDR_W - PIN_W;

  logic [PIN_W-1:0] sync_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pins;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_comb begin
    if (pin_mode) eff_addr = {reg_addr[ADDR_W-1 -: HI_W], sync_q[STAGES-1]};
    else          eff_addr = reg_addr;
  end
endmodule

// File: rtl/mdrop_select.sv
module mdrop_select
  import mdrop_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              filt_on,
  input  logic              take,
  input  word_kind_t        kind,
  input  logic [ADDR_W-1:0] word_byte,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              irq_clr,
  output logic              pass,
  output logic              irq
);
  logic selected_q;

  always_comb begin
    if (!filt_on) pass = 1'b1;
    else          pass = (kind == WK_DATA) && selected_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !filt_on) selected_q <= 1'b0;
    else if (take && kind == WK_ADDR) selected_q <= (word_byte == eff_addr);
  end

  // set takes priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else if (take && kind == WK_ADDR) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end
endmodule

// File: rtl/mdrop_out_stage.sv
module mdrop_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              space
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIN_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_multidrop,
  input  logic              cfg_filter,
  input  logic              cfg_pin_addr,
  input  logic [DATA_W-1:0] station_addr,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W:0]   in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              addr_irq,
  input  logic              addr_irq_clr,
  output logic              parity_check_en
);
  localparam int NINTH = DATA_W;

  logic              take;
  logic              pass;
  logic              filt_on;
  word_kind_t        kind;
  logic [DATA_W-1:0] eff_addr;

  assign filt_on         = cfg_multidrop && cfg_filter;
  assign kind            = classify(cfg_multidrop, in_word[NINTH]);
  assign take            = in_valid && in_ready;
  assign parity_check_en = !cfg_multidrop;

  mdrop_addr_src #(.ADDR_W(DATA_W), .PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_addr (
    .clk(clk), .rst_n(rst_n), .pin_mode(cfg_pin_addr), .reg_addr(station_addr),
    .pins(addr_pins), .eff_addr(eff_addr)
  );

  mdrop_select #(.ADDR_W(DATA_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .filt_on(filt_on), .take(take), .kind(kind),
    .word_byte(in_word[DATA_W-1:0]), .eff_addr(eff_addr), .irq_clr(addr_irq_clr),
    .pass(pass), .irq(addr_irq)
  );

  mdrop_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .push(take && pass), .push_data(in_word[DATA_W-1:0]),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .space(in_ready)
  );
endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_multidrop,
  input logic              cfg_filter,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W:0]   in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              addr_irq,
  input logic              addr_irq_clr
);
  logic acc, acc_addr;
  assign acc      = in_valid && in_ready;
  assign acc_addr = acc && cfg_multidrop && in_word[DATA_W];

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr |=> addr_irq);

  p_irq_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_irq_clr && !acc_addr |=> !addr_irq);

  p_addr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr && cfg_filter |=> !out_valid);

  p_plain_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cfg_multidrop |=> out_valid && out_data == $past(in_word[DATA_W-1:0]));
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_multidrop(cfg_multidrop), .cfg_filter(cfg_filter),
  .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .addr_irq(addr_irq), .addr_irq_clr(addr_irq_clr)
);

// File: tb/mdrop_rx_filter_tb.sv
module mdrop_rx_filter_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_multidrop = 0, cfg_filter = 0, cfg_pin_addr = 0;
  logic [7:0] station_addr = 8'h00;
  logic [3:0] addr_pins = 4'h0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, addr_irq, addr_irq_clr = 0;
  logic parity_check_en;
  logic [8:0] in_word = '0;
  logic [7:0] out_data;
  int checks = 0, errors = 0;
  bit exp_sel = 0, exp_irq = 0;

  always #4 clk = ~clk;

  mdrop_rx_filter u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] eff_addr();
    return cfg_pin_addr ? {station_addr[7:4], addr_pins} : station_addr;
  endfunction

  function automatic bit exp_pass(input logic [8:0] w);
    if (!(cfg_multidrop && cfg_filter)) return 1;
    return !w[8] && exp_sel;
  endfunction

  task automatic set_cfg(input bit md, input bit fl, input bit pm);
    @(negedge clk);
    cfg_multidrop = md; cfg_filter = fl; cfg_pin_addr = pm;
    if (!(md && fl)) exp_sel = 0;
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p);
    @(negedge clk);
    addr_pins = p;
    repeat (3) @(negedge clk);
  endtask

  // send one word with out_ready high, check result one clock later
  task automatic send(input logic [8:0] w, input string req, input bit clr = 0);
    bit pass, isaddr;
    pass = exp_pass(w);
    isaddr = cfg_multidrop && w[8];
    @(negedge clk);
    in_word = w; in_valid = 1; addr_irq_clr = clr;
    chk(in_ready === 1'b1, {req, " in_ready"}, in_ready, 1);
    @(negedge clk);
    in_valid = 0; addr_irq_clr = 0;
    if (cfg_multidrop && cfg_filter && isaddr) exp_sel = (w[7:0] == eff_addr());
    if (isaddr) exp_irq = 1; else if (clr) exp_irq = 0;
    chk(out_valid === pass, {req, " out_valid"}, out_valid, pass);
    if (pass) chk(out_data === w[7:0], {req, " out_data"}, out_data, w[7:0]);
    chk(addr_irq === exp_irq, {req, " addr_irq"}, addr_irq, exp_irq);
  endtask

  task automatic clear_irq();
    @(negedge clk);
    addr_irq_clr = 1;
    @(negedge clk);
    addr_irq_clr = 0;
    exp_irq = 0;
    chk(addr_irq === 1'b0, "R4 clear", addr_irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid === 0, "R1 out_valid", out_valid, 0);
    chk(addr_irq === 0, "R1 addr_irq", addr_irq, 0);
    chk(in_ready === 1, "R1 in_ready", in_ready, 1);
    // R2 plain mode, ninth bit ignored
    chk(parity_check_en === 1, "R2 parity_en", parity_check_en, 1);
    send(9'h1A5, "R2");
    send(9'h03C, "R2");
    // R3 multidrop without filter
    set_cfg(1, 0, 0);
    chk(parity_check_en === 0, "R3 parity_en", parity_check_en, 0);
    send(9'h012, "R3 data");
    send(9'h155, "R3 addr");
    // R4 clear, then same-cycle set wins
    clear_irq();
    send(9'h1AA, "R4 set-vs-clear", 1);
    clear_irq();
    // R7 filter on: discards until match
    station_addr = 8'h5C;
    set_cfg(1, 1, 0);
    send(9'h011, "R7 unselected");
    // R5 matching address, then data
    send(9'h15C, "R6 addr not fwd");
    send(9'h077, "R5 data");
    send(9'h078, "R5 data2");
    // R6 non-matching address
    send(9'h15D, "R6 addr");
    send(9'h099, "R6 data dropped");
    // R7 re-enable clears selection
    send(9'h15C, "R7 match");
    set_cfg(1, 0, 0);
    set_cfg(1, 1, 0);
    send(9'h033, "R7 after re-enable");
    // R8 pin addressing
    set_cfg(1, 1, 1);
    set_pins(4'h9);
    send(9'h159, "R8 pin addr");
    send(9'h0E1, "R8 data");
    set_pins(4'h3);
    send(9'h122, "R8 old pins");
    send(9'h0E2, "R8 data");
    send(9'h153, "R8 new pins");
    send(9'h0E3, "R8 data");
    // R9 back-pressure
    set_cfg(1, 0, 0);
    @(negedge clk);
    out_ready = 0; in_word = 9'h0C4; in_valid = 1;
    @(negedge clk);
    in_word = 9'h0D5;
    chk(out_valid === 1 && out_data === 8'hC4, "R9 first", out_data, 8'hC4);
    chk(in_ready === 0, "R9 stall", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(out_data === 8'hC4, "R9 hold", out_data, 8'hC4);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1 && out_data === 8'hD5, "R9 second", out_data, 8'hD5);
    @(negedge clk);
    chk(out_valid === 0, "R9 drained", out_valid, 0);
    // random phase
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      logic [8:0] w;
      if (r == 0) set_cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      else if (r == 1) set_pins($urandom_range(0, 15));
      else if (r == 2) clear_irq();
      w = {1'($urandom_range(0, 1)), 8'($urandom_range(0, 255))};
      if (w[8] && $urandom_range(0, 1)) w[7:0] = eff_addr();
      send(w, w[8] ? "R6 rand addr" : "R5 rand data", $urandom_range(0, 7) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule